// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Result Reader

This block sits on the host side of a three-wire serial link to a delta-sigma converter. The three wires are an active-low select, a serial clock that the host drives, and a data line that the converter drives. A single-cycle `start` request makes the block pull select low. The converter then shows its conversion-busy level on the data line, and the block watches that line until it reads low. The block then produces a burst of exactly nineteen clock pulses and captures one nineteen-bit frame. After the last pulse it releases select and publishes a sixteen-bit result, the sign, two range flags and a framing flag, together with a one-cycle valid strobe.

The state machine has six states. `ST_IDLE` waits for `start`. `ST_SELECT` is one settling cycle with select low. `ST_POLL` samples the ready level every system clock. `ST_CLOCK` runs the serial clock and shifts the bits in. `ST_DONE` is one cycle that registers the decoded word. `ST_TMO` raises the timeout flag. The transitions are as follows:
- idle→select on `start`.
- select→poll unconditionally.
- poll→clock when the data line reads low.
- poll→tmo when the poll counter reaches `poll_limit` with the line still high.
- clock→done on the falling edge of the nineteenth pulse.
- done→idle and tmo→idle unconditionally.

The serial clock rests low. Each half period lasts `half_div` system clocks, and any value below two is treated as two. The block samples the data line in the system cycle in which it raises the serial clock.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `valid` is 0 and `busy` is 0.
- R2: After `start`, `cs_n` is 0. While the data line reads 1, no rising edge appears on `sck`.
- R3: Each high phase of `sck` lasts max(`half_div`, 2) system clock cycles.
- R4: A read produces exactly 19 rising edges on `sck`. After the 19th falling edge, `cs_n` returns to 1, and `sck` is never 1 while `cs_n` is 1.
- R5: The frame arrives with its most significant bit first. Bit 18 is the ready bit, bit 17 is the dummy bit, bit 16 is the sign, and bits 15..0 are the result with the MSB first. `result` carries frame bits 15..0 and `sign` carries frame bit 16.
- R6: `over_range` is 1 exactly when frame bits 16 and 15 are both 1. `under_range` is 1 exactly when both are 0. The two flags are never 1 together.
- R7: `frame_err` is 1 exactly when frame bit 17 was captured as 1.
- R8: `valid` is a single-cycle pulse after each completed frame, and the output fields are valid in that cycle.
- R9: Suppose the data line stays 1 for `poll_limit`+1 polling cycles. Then `timeout` becomes 1, `cs_n` returns to 1, `valid` is not pulsed, and no `sck` edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one read (taken in idle only) |
| half_div | input | DIV_W | Serial clock half period in system clocks (minimum 2) |
| poll_limit | input | TO_W | Ready-poll timeout in system clocks |
| sdo | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low converter select |
| sck | output | 1 | Serial clock to the converter |
| busy | output | 1 | A read is in progress |
| result | output | DATA_W | Captured result word |
| sign | output | 1 | Captured sign bit |
| over_range | output | 1 | Input above positive full scale |
| under_range | output | 1 | Input below negative full scale |
| frame_err | output | 1 | Dummy bit read as 1 |
| timeout | output | 1 | Ready poll expired |
| valid | output | 1 | One-cycle result strobe |

## Verification
If the pulse counter is wrong, the frame is one bit off: the captured word comes out shifted and the rising-edge count differs from nineteen. Both show up on the first read. If the divider is wrong, the high-phase width is off, which shows within the first pulse. If the poll logic is wrong, the block either clocks while the converter is still busy, which the converter model counts as an early edge, or it never reaches the timeout. Each of these shows up within a single read of at most a few hundred cycles.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_POLL,
        ST_CLOCK,
        ST_DONE,
        ST_TMO
    } rd_state_t;

    localparam int STATUS_BITS = 3;

endpackage

// File: rtl/adc_rd_sck_gen.sv
module adc_rd_sck_gen #(
    parameter int DIV_W   = 8,
    parameter int PULSES  = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             sck,
    output logic             sample,
    output logic             last_fall
);
    localparam int PC_W = $clog2(PULSES + 1);

    logic [DIV_W-1:0] eff_half;
    logic [DIV_W-1:0] hcnt_q;
    logic [PC_W-1:0]  pulses_q;
    logic             sck_q;
    logic             edge_now;

    always_comb begin
        eff_half = (half_div < DIV_W'(2)) ? DIV_W'(2) : half_div;
    end

    assign edge_now  = run && (hcnt_q == eff_half - DIV_W'(1));
    assign sample    = edge_now && !sck_q;
    assign last_fall = edge_now && sck_q && (pulses_q == PC_W'(PULSES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt_q   <= '0;
            sck_q    <= 1'b0;
            pulses_q <= '0;
        end else if (!run) begin
            hcnt_q   <= '0;
            sck_q    <= 1'b0;
            pulses_q <= '0;
        end else if (edge_now) begin
            hcnt_q <= '0;
            sck_q  <= !sck_q;
            if (sck_q) begin
                pulses_q <= last_fall ? '0 : pulses_q + PC_W'(1);
            end
        end else begin
            hcnt_q <= hcnt_q + DIV_W'(1);
        end
    end

    assign sck = sck_q;

    a_r4_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pulses_q <= PC_W'(PULSES - 1));

    a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sck_q);

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int FRAME_W = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               shift,
    input  logic               din,
    output logic [FRAME_W-1:0] frame
);
    logic [FRAME_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (clear) begin
            sr_q <= '0;
        end else if (shift) begin
            sr_q <= {sr_q[FRAME_W-2:0], din};
        end
    end

    assign frame = sr_q;

endmodule

// File: rtl/adc_rd_decode.sv
module adc_rd_decode #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W+2:0] frame,
    output logic [DATA_W-1:0] word,
    output logic              sgn,
    output logic              ovr,
    output logic              und,
    output logic              ferr
);
    always_comb begin
        word = frame[DATA_W-1:0];
        sgn  = frame[DATA_W];
        ferr = frame[DATA_W+1];
        ovr  = frame[DATA_W] && frame[DATA_W-1];
        und  = !frame[DATA_W] && !frame[DATA_W-1];
    end

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    parameter int TO_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [TO_W-1:0]   poll_limit,
    input  logic              sdo,
    output logic              cs_n,
    output logic              sck,
    output logic              busy,
    output logic [DATA_W-1:0] result,
    output logic              sign,
    output logic              over_range,
    output logic              under_range,
    output logic              frame_err,
    output logic              timeout,
    output logic              valid
);
    localparam int FRAME_W = DATA_W + STATUS_BITS;

    rd_state_t state_q, state_d;
    logic [TO_W-1:0]    poll_cnt_q;
    logic               sample, last_fall;
    logic [FRAME_W-1:0] frame;
    logic [DATA_W-1:0]  dec_word;
    logic               dec_sgn, dec_ovr, dec_und, dec_ferr;

    logic               cs_n_q, valid_q, tmo_q, sign_q, ovr_q, und_q, ferr_q;
    logic [DATA_W-1:0]  result_q;

    adc_rd_sck_gen #(.DIV_W(DIV_W), .PULSES(FRAME_W)) u_sck (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state_q == ST_CLOCK),
        .half_div  (half_div),
        .sck       (sck),
        .sample    (sample),
        .last_fall (last_fall)
    );

    adc_rd_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q == ST_SELECT),
        .shift (sample),
        .din   (sdo),
        .frame (frame)
    );

    adc_rd_decode #(.DATA_W(DATA_W)) u_dec (
        .frame (frame),
        .word  (dec_word),
        .sgn   (dec_sgn),
        .ovr   (dec_ovr),
        .und   (dec_und),
        .ferr  (dec_ferr)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SELECT;
            ST_SELECT: state_d = ST_POLL;
            ST_POLL: begin
                if (!sdo)                          state_d = ST_CLOCK;
                else if (poll_cnt_q == poll_limit) state_d = ST_TMO;
            end
            ST_CLOCK:  if (last_fall) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_TMO:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            poll_cnt_q <= '0;
        end else begin
            state_q    <= state_d;
            poll_cnt_q <= (state_q == ST_POLL) ? poll_cnt_q + TO_W'(1) : '0;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q   <= 1'b1;
            valid_q  <= 1'b0;
            tmo_q    <= 1'b0;
            result_q <= '0;
            sign_q   <= 1'b0;
            ovr_q    <= 1'b0;
            und_q    <= 1'b0;
            ferr_q   <= 1'b0;
        end else begin
            cs_n_q  <= !(state_d == ST_SELECT || state_d == ST_POLL ||
                         state_d == ST_CLOCK);
            valid_q <= (state_q == ST_DONE);
            if (state_q == ST_IDLE && start) begin
                tmo_q  <= 1'b0;
                ovr_q  <= 1'b0;
                und_q  <= 1'b0;
                ferr_q <= 1'b0;
            end
            if (state_q == ST_TMO) begin
                tmo_q <= 1'b1;
            end
            if (state_q == ST_DONE) begin
                result_q <= dec_word;
                sign_q   <= dec_sgn;
                ovr_q    <= dec_ovr;
                und_q    <= dec_und;
                ferr_q   <= dec_ferr;
            end
        end
    end

    assign cs_n        = cs_n_q;
    assign busy        = (state_q != ST_IDLE);
    assign valid       = valid_q;
    assign timeout     = tmo_q;
    assign result      = result_q;
    assign sign        = sign_q;
    assign over_range  = ovr_q;
    assign under_range = und_q;
    assign frame_err   = ferr_q;

    a_r4_sck_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);

    a_r2_quiet_while_polling: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL) |-> !sck);

    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    a_r6_range_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(over_range && under_range));

    a_r9_timeout_releases: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> (cs_n && !valid));

endmodule

// File: tb/test_adc_frame_reader.sv
module test_adc_frame_reader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  half_div = 8'd2;
    logic [15:0] poll_limit = 16'd500;
    logic        sdo;
    logic        cs_n, sck, busy, sign, over_range, under_range;
    logic        frame_err, timeout, valid;
    logic [15:0] result;

    int vectors = 0;
    int errors  = 0;

    // converter model state
    logic        model_ready = 1'b0;
    logic [18:0] tx_frame = '0;
    int          bit_idx = 18;
    int          rises = 0;
    int          early = 0;
    int          hi_run = 0;
    int          last_hi = 0;
    logic        sck_prev = 1'b0;

    always #5 clk = !clk;

    adc_frame_reader i_adc_frame_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .half_div(half_div),
        .poll_limit(poll_limit), .sdo(sdo), .cs_n(cs_n), .sck(sck),
        .busy(busy), .result(result), .sign(sign), .over_range(over_range),
        .under_range(under_range), .frame_err(frame_err), .timeout(timeout),
        .valid(valid)
    );

    assign sdo = cs_n ? 1'b1 :
                 (!model_ready ? 1'b1 :
                 ((bit_idx < 0) ? 1'b1 : tx_frame[bit_idx]));

    always @(negedge sck) begin
        if (!cs_n && model_ready) bit_idx <= bit_idx - 1;
    end

    always @(posedge sck) begin
        rises <= rises + 1;
        if (!model_ready) early <= early + 1;
    end

    always @(negedge clk) begin
        if (sck) hi_run <= hi_run + 1;
        else if (sck_prev) begin
            last_hi <= hi_run;
            hi_run  <= 0;
        end
        sck_prev <= sck;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_frame(input logic [7:0] div, input bit s, input bit dum,
                             input logic [15:0] data, input int delay);
        int waited;
        int eff;
        bit ovr_e, und_e;
        half_div    = div;
        tx_frame    = {1'b0, dum, s, data};
        bit_idx     = 18;
        model_ready = 1'b0;
        rises       = 0;
        early       = 0;
        last_hi     = 0;
        pulse_start();
        check(cs_n == 1'b0, "R2", cs_n, 0);
        repeat (delay) @(negedge clk);
        model_ready = 1'b1;
        waited = 0;
        while (!valid && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        eff   = (div < 2) ? 2 : div;
        ovr_e = s & data[15];
        und_e = !s & !data[15];
        check(valid == 1'b1, "R8", valid, 1);
        check(result == data, "R5", result, data);
        check(sign == s, "R5", sign, s);
        check(over_range == ovr_e, "R6", over_range, ovr_e);
        check(under_range == und_e, "R6", under_range, und_e);
        check(frame_err == dum, "R7", frame_err, dum);
        check(rises == 19, "R4", rises, 19);
        check(early == 0, "R2", early, 0);
        check(cs_n == 1'b1, "R4", cs_n, 1);
        check(last_hi == eff, "R3", last_hi, eff);
        @(negedge clk);
        check(valid == 1'b0, "R8", valid, 0);
    endtask

    initial begin
        logic [14:0] pats [4];
        pats[0] = 15'h0000;
        pats[1] = 15'h7FFF;
        pats[2] = 15'h5555;
        pats[3] = 15'h2A3C;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1, "R1", cs_n, 1);
        check(sck == 1'b0, "R1", sck, 0);
        check(valid == 1'b0, "R1", valid, 0);
        check(busy == 1'b0, "R1", busy, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int d = 0; d < 3; d++) begin
            for (int s = 0; s < 2; s++) begin
                for (int m = 0; m < 2; m++) begin
                    for (int p = 0; p < 4; p++) begin
                        for (int dm = 0; dm < 2; dm++) begin
                            run_frame(8'(d * 2 + 1), s[0], dm[0],
                                      {m[0], pats[p]}, p * 3);
                        end
                    end
                end
            end
        end
        // R9 timeout: converter never ready
        poll_limit  = 16'd20;
        model_ready = 1'b0;
        rises       = 0;
        begin
            int w;
            bit saw_valid;
            saw_valid = 1'b0;
            pulse_start();
            w = 0;
            while (!timeout && w < 200) begin
                @(negedge clk);
                if (valid) saw_valid = 1'b1;
                w++;
            end
            check(timeout == 1'b1, "R9", timeout, 1);
            check(cs_n == 1'b1, "R9", cs_n, 1);
            check(rises == 0, "R9", rises, 0);
            check(saw_valid == 1'b0, "R9", saw_valid, 0);
            check(w >= 21, "R9", w, 21);
        end
        // a normal read after timeout clears the flag
        poll_limit = 16'd500;
        run_frame(8'd4, 1'b1, 1'b0, 16'hC3A5, 2);
        check(timeout == 1'b0, "R9", timeout, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule